// File: doc/BRIEF.md
# Subroutine Call Bus Sequencer

This block performs the memory traffic of a three-byte subroutine call for a small processor with 8-bit data and 16-bit addresses. It first runs an opcode fetch that is stretched to six T-states, and the stack pointer is stepped down during the two extra states. It then reads the low and high bytes of the target address, pushes the return address onto a stack in memory, and loads the program counter with the target. The whole call takes eighteen T-states (6 + 3 + 3 + 3 + 3) and makes five memory accesses, at most one in each machine cycle. One clock equals one T-state.

Software-free control is plain. While the sequencer is idle, `ld_en` loads the program counter and stack pointer, and a `start` pulse begins a call. `busy` covers the whole call. `done` marks its final T-state, and `t_count` numbers the T-states. The memory bus is a simple synchronous port with no wait states and no back-pressure. Each strobe lasts exactly one clock. The memory must register read data on the clock edge that ends the read strobe. A write is taken on the clock edge that ends the write strobe.

Top module: `call_sequencer`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a call, leaves the block idle. After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0, `t_count` is 0, and `pc_q` and `sp_q` are 0x0000.
- R2: While idle, `ld_en` loads `ld_pc` into the program counter and `ld_sp` into the stack pointer. While busy, `ld_en` has no effect.
- R3: Counting the first T-state after start is accepted as T-state 1, `mem_addr` is held for each whole machine cycle as follows:
  - T-states 1-6 (opcode fetch): PC
  - T-states 7-9 (low target byte read): PC+1
  - T-states 10-12 (high target byte read): PC+2
  - T-states 13-15 (return high byte write): SP-1
  - T-states 16-18 (return low byte write): SP-2
  
  PC and SP are the values at the start of the call, and all address arithmetic is modulo 2^16.
- R4: The fetch cycle lasts 6 T-states and each read or write cycle lasts 3. `done` is high for exactly one clock, in T-state 18, and `busy` is low in the following clock.
- R5: `mem_rd` is high only in T-states 2, 8 and 11. `mem_wr` is high only in T-states 14 and 17. The two strobes are never high together.
- R6: The pushed return address is start PC + 3. Its high byte is driven on `mem_wdata` during T-states 13-15, and its low byte during T-states 16-18.
- R7: The program counter reads start PC + 3 through T-state 18. From the next clock it holds the target, with the high byte taken from the second read and the low byte from the first read.
- R8: After the call the stack pointer is 2 lower than at the start, modulo 2^16.
- R9: `start` is accepted only when idle and begins T-state 1 in the next clock. A start pulse raised during a call has no effect on its timing or its results.
- R10: `t_count` is 0 when idle and counts 1 through 18 across the T-states of a call.
- R11: The byte read in the fetch cycle is presented on `opcode_q` from T-state 4 onward and is held until the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call (sampled when idle) |
| ld_en | input | 1 | Load PC and SP when idle |
| ld_pc | input | 16 | Program counter load value |
| ld_sp | input | 16 | Stack pointer load value |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (registered by memory) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Call in progress |
| done | output | 1 | Final T-state of the call |
| t_count | output | 5 | T-state number within the call |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| opcode_q | output | 8 | Last fetched opcode byte |

## Verification
The embedded properties watch several behaviours on every cycle:
- the two strobes never overlap, and each strobe lasts a single clock;
- the address stays fixed within a machine cycle;
- `done` appears only when the T-state count reaches eighteen and is followed by idle;
- the return address on the stack equals the entry PC plus three, and the stack pointer ends two lower;
- the program counter takes the assembled target right after the last state;
- a running call advances one T-state per clock whatever `start` does.

Only the bench scenarios can show that the right bytes reach the right addresses in the right T-states across wrap-around at 0xFFFF. They also show that loads and start pulses injected mid-call leave no trace, and that a reset in the middle of a call returns the block to idle.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

  typedef enum logic [2:0] {
    MC_IDLE  = 3'd0,
    MC_FETCH = 3'd1,
    MC_RDLO  = 3'd2,
    MC_RDHI  = 3'd3,
    MC_WRHI  = 3'd4,
    MC_WRLO  = 3'd5
  } mcyc_e;

  function automatic mcyc_e mc_next(input mcyc_e m);
    case (m)
      MC_FETCH: return MC_RDLO;
      MC_RDLO:  return MC_RDHI;
      MC_RDHI:  return MC_WRHI;
      MC_WRHI:  return MC_WRLO;
      default:  return MC_IDLE;
    endcase
  endfunction

  function automatic logic mc_is_read(input mcyc_e m);
    return (m == MC_FETCH) || (m == MC_RDLO) || (m == MC_RDHI);
  endfunction

  function automatic logic mc_is_write(input mcyc_e m);
    return (m == MC_WRHI) || (m == MC_WRLO);
  endfunction

endpackage

// File: rtl/call_seq_timer.sv
module call_seq_timer
  import call_seq_pkg::*;
#(
  parameter int FETCH_T = 6,
  parameter int RW_T    = 3,
  parameter int TW      = 3,
  parameter int TCW     = 5,
  parameter int TOTAL_T = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output mcyc_e          mcyc,
  output logic [TW-1:0]  tst,
  output logic           last_t,
  output logic           busy,
  output logic           done,
  output logic [TCW-1:0] tcount
);

  logic [TW-1:0] cur_len;
  mcyc_e         nxt_mc;

  always_comb begin
    cur_len = (mcyc == MC_FETCH) ? TW'(FETCH_T) : TW'(RW_T);
    busy    = (mcyc != MC_IDLE);
    last_t  = busy && (tst == cur_len);
    done    = last_t && (mcyc == MC_WRLO);
    nxt_mc  = mc_next(mcyc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcyc   <= MC_IDLE;
      tst    <= '0;
      tcount <= '0;
    end else if (mcyc == MC_IDLE) begin
      if (start) begin
        mcyc   <= MC_FETCH;
        tst    <= TW'(1);
        tcount <= TCW'(1);
      end
    end else if (last_t) begin
      mcyc <= nxt_mc;
      if (nxt_mc == MC_IDLE) begin
        tst    <= '0;
        tcount <= '0;
      end else begin
        tst    <= TW'(1);
        tcount <= tcount + TCW'(1);
      end
    end else begin
      tst    <= tst + TW'(1);
      tcount <= tcount + TCW'(1);
    end
  end

  // R4: done only in the last counted T-state
  p_done_total_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (tcount == TCW'(TOTAL_T)));

  // R4: idle right after the final state
  p_idle_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R9: a running machine cycle advances by one regardless of start
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_t) |=> (mcyc == $past(mcyc)) && (tcount == $past(tcount) + TCW'(1)));

endmodule

// File: rtl/call_seq_regs.sv
module call_seq_regs
  import call_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int TW        = 3,
  parameter int SP_PREP_T = 4,
  parameter int CAP_T     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  mcyc_e         mcyc,
  input  logic [TW-1:0] tst,
  input  logic          last_t,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_pc,
  input  logic [AW-1:0] ld_sp,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic [DW-1:0] opcode,
  output logic [DW-1:0] tmp_lo,
  output logic [DW-1:0] tmp_hi
);

  logic cap_now, pc_step, pc_jump, sp_step;

  always_comb begin
    cap_now = (tst == TW'(CAP_T));
    pc_step = last_t && mc_is_read(mcyc);
    pc_jump = last_t && (mcyc == MC_WRLO);
    sp_step = ((mcyc == MC_FETCH) && (tst == TW'(SP_PREP_T))) ||
              ((mcyc == MC_WRHI) && last_t);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0;
      tmp_lo <= '0;
      tmp_hi <= '0;
    end else if (cap_now) begin
      case (mcyc)
        MC_FETCH: opcode <= rdata;
        MC_RDLO:  tmp_lo <= rdata;
        MC_RDHI:  tmp_hi <= rdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if ((mcyc == MC_IDLE) && ld_en) begin
      pc <= ld_pc;
    end else if (pc_jump) begin
      pc <= {tmp_hi, tmp_lo};
    end else if (pc_step) begin
      pc <= pc + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if ((mcyc == MC_IDLE) && ld_en) begin
      sp <= ld_sp;
    end else if (sp_step) begin
      sp <= sp - AW'(1);
    end
  end

  // entry snapshot used only by the properties below
  logic [AW-1:0] pc_entry, sp_entry;
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_entry <= '0;
      sp_entry <= '0;
    end else if ((mcyc == MC_FETCH) && (tst == TW'(1))) begin
      pc_entry <= pc;
      sp_entry <= sp;
    end
  end

  // R6: the pushed address is the entry PC plus three
  p_ret_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (mcyc == MC_WRHI) |-> (pc == pc_entry + AW'(3)));

  // R8: stack pointer two below entry during the last write cycle
  p_sp_end_r8: assert property (@(posedge clk) disable iff (rst)
    pc_jump |-> (sp == sp_entry - AW'(2)));

  // R7: target loaded from the two fetched bytes
  p_pc_target_r7: assert property (@(posedge clk) disable iff (rst)
    pc_jump |=> (pc == {$past(tmp_hi), $past(tmp_lo)}));

endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
  import call_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int TW    = 3,
  parameter int STB_T = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  mcyc_e         mcyc,
  input  logic [TW-1:0] tst,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rd,
  output logic          wr
);

  localparam int NB = AW / DW;

  logic [DW-1:0] pc_byte [NB];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_split
      assign pc_byte[g] = pc[g*DW +: DW];
    end
  endgenerate

  always_comb begin
    addr  = '0;
    wdata = '0;
    if (mc_is_read(mcyc))  addr = pc;
    if (mc_is_write(mcyc)) addr = sp;
    if (mcyc == MC_WRHI)   wdata = pc_byte[NB-1];
    if (mcyc == MC_WRLO)   wdata = pc_byte[0];
    rd = mc_is_read(mcyc)  && (tst == TW'(STB_T));
    wr = mc_is_write(mcyc) && (tst == TW'(STB_T));
  end

  // R3: address held across a machine cycle
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    ((mcyc != MC_IDLE) && (tst != TW'(1))) |-> $stable(addr));

  // R5: each strobe is a single-clock pulse
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) |=> !(rd || wr));

endmodule

// File: rtl/call_sequencer.sv
module call_sequencer
  import call_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int FETCH_T   = 6,
  parameter int RW_T      = 3,
  parameter int STB_T     = 2,
  parameter int SP_PREP_T = 4,
  localparam int TOTAL_T  = FETCH_T + 4 * RW_T,
  localparam int TCW      = $clog2(TOTAL_T + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           ld_en,
  input  logic [AW-1:0]  ld_pc,
  input  logic [AW-1:0]  ld_sp,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           busy,
  output logic           done,
  output logic [TCW-1:0] t_count,
  output logic [AW-1:0]  pc_q,
  output logic [AW-1:0]  sp_q,
  output logic [DW-1:0]  opcode_q
);

  localparam int MAXT  = (FETCH_T > RW_T) ? FETCH_T : RW_T;
  localparam int TW    = $clog2(MAXT + 1);
  localparam int CAP_T = STB_T + 1;

  mcyc_e         mcyc;
  logic [TW-1:0] tst;
  logic          last_t;
  logic [DW-1:0] tmp_lo, tmp_hi;

  call_seq_timer #(
    .FETCH_T(FETCH_T), .RW_T(RW_T), .TW(TW), .TCW(TCW), .TOTAL_T(TOTAL_T)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .mcyc(mcyc), .tst(tst), .last_t(last_t),
    .busy(busy), .done(done), .tcount(t_count)
  );

  call_seq_regs #(
    .AW(AW), .DW(DW), .TW(TW), .SP_PREP_T(SP_PREP_T), .CAP_T(CAP_T)
  ) u_regs (
    .clk(clk), .rst(rst), .mcyc(mcyc), .tst(tst), .last_t(last_t),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp), .rdata(mem_rdata),
    .pc(pc_q), .sp(sp_q), .opcode(opcode_q), .tmp_lo(tmp_lo), .tmp_hi(tmp_hi)
  );

  call_seq_bus #(
    .AW(AW), .DW(DW), .TW(TW), .STB_T(STB_T)
  ) u_bus (
    .clk(clk), .rst(rst), .mcyc(mcyc), .tst(tst), .pc(pc_q), .sp(sp_q),
    .addr(mem_addr), .wdata(mem_wdata), .rd(mem_rd), .wr(mem_wr)
  );

  // R5: never read and write in the same clock
  p_no_dual_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R4: done is a one-clock pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: no bus activity while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/call_sequencer_test.sv
module call_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_pc = '0;
  logic [15:0] ld_sp = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rd, mem_wr, busy, done;
  logic [4:0]  t_count;
  logic [15:0] pc_q, sp_q;
  logic [7:0]  opcode_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [15:0] img_pc = '0;
  logic [7:0]  img_op = '0, img_lo = '0, img_hi = '0;

  always #5 clk = ~clk;

  call_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done), .t_count(t_count),
    .pc_q(pc_q), .sp_q(sp_q), .opcode_q(opcode_q)
  );

  function automatic logic [7:0] rom(input logic [15:0] a);
    if (a == img_pc)                return img_op;
    if (a == img_pc + 16'd1)        return img_lo;
    if (a == img_pc + 16'd2)        return img_hi;
    return 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rom(mem_addr);

  function automatic logic [15:0] exp_addr(input int i, input logic [15:0] p, input logic [15:0] s);
    if (i <= 6)  return p;
    if (i <= 9)  return p + 16'd1;
    if (i <= 12) return p + 16'd2;
    if (i <= 15) return s - 16'd1;
    return s - 16'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_regs(input logic [15:0] p, input logic [15:0] s);
    @(negedge clk);
    ld_en = 1'b1; ld_pc = p; ld_sp = s;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_call(input logic [15:0] p, input logic [15:0] s,
                          input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                          input bit inject);
    logic [15:0] ret;
    ret = p + 16'd3;
    load_regs(p, s);
    chk(pc_q == p && sp_q == s, "R2 load pc/sp", {pc_q, sp_q}, {p, s});
    img_pc = p; img_op = op; img_lo = lo; img_hi = hi;
    start = 1'b1;
    for (int i = 1; i <= 18; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      chk(t_count == 5'(i), "R10 t_count", 32'(t_count), 32'(i));
      chk(busy == 1'b1, "R9 busy during call", 32'(busy), 1);
      chk(mem_addr == exp_addr(i, p, s), "R3 address", 32'(mem_addr), 32'(exp_addr(i, p, s)));
      chk(mem_rd == (i == 2 || i == 8 || i == 11), "R5 read strobe", 32'(mem_rd), 32'(i));
      chk(mem_wr == (i == 14 || i == 17), "R5 write strobe", 32'(mem_wr), 32'(i));
      chk(done == (i == 18), "R4 done timing", 32'(done), 32'(i));
      if (i >= 13 && i <= 15) chk(mem_wdata == ret[15:8], "R6 return high byte", 32'(mem_wdata), 32'(ret[15:8]));
      if (i >= 16)            chk(mem_wdata == ret[7:0],  "R6 return low byte",  32'(mem_wdata), 32'(ret[7:0]));
      if (i >= 4)             chk(opcode_q == op, "R11 opcode", 32'(opcode_q), 32'(op));
      if (i == 18)            chk(pc_q == ret, "R7 pc before jump", 32'(pc_q), 32'(ret));
      if (inject && i == 5) begin
        start = 1'b1; ld_en = 1'b1; ld_pc = ~p; ld_sp = ~s;
      end
      if (inject && i == 6) begin
        start = 1'b0; ld_en = 1'b0;
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R4 idle after call", 32'(busy), 0);
    chk(t_count == 5'd0, "R10 t_count idle", 32'(t_count), 0);
    chk(pc_q == {hi, lo}, "R7 pc target", 32'(pc_q), 32'({hi, lo}));
    chk(sp_q == s - 16'd2, "R8 sp end", 32'(sp_q), 32'(s - 16'd2));
    chk(opcode_q == op, "R11 opcode held", 32'(opcode_q), 32'(op));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 reset idle", {busy, done, mem_rd, mem_wr}, 0);
    chk(t_count == 0 && pc_q == 0 && sp_q == 0, "R1 reset regs", {pc_q, sp_q}, 0);

    run_call(16'h2000, 16'h3000, 8'hCD, 8'h67, 8'h45, 1'b0);
    run_call(16'hFFFE, 16'h0001, 8'hC4, 8'h10, 8'h80, 1'b0);
    run_call(16'h1234, 16'h0000, 8'hCC, 8'hFF, 8'hFF, 1'b0);
    run_call(16'h0100, 16'h8000, 8'hCD, 8'hAA, 8'h55, 1'b1);

    // R1: reset in the middle of a call
    load_regs(16'h4000, 16'h5000);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr && t_count == 0, "R1 mid-call reset", {busy, t_count}, 0);
    chk(pc_q == 0 && sp_q == 0, "R1 mid-call reset regs", {pc_q, sp_q}, 0);
    rst = 1'b0;

    // R9: no start keeps the block idle
    repeat (3) @(negedge clk);
    chk(!busy && t_count == 0, "R9 idle without start", 32'(busy), 0);

    for (int k = 0; k < 40; k++) begin
      run_call(16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               1'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule